// File: doc/BRIEF.md
# Per-CPU Prioritized Interrupt Delivery Unit

The unit collects a small set of interrupt sources and delivers each one to one or more CPUs. Each CPU has its own interrupt line. Every source carries a configuration word and a destination mask. The configuration word holds the mask, polarity, trigger sense, a 4-bit priority and an 8-bit vector. Every CPU has a task-priority threshold, a set of raised requests and a nested set of requests in service. A raised request reaches the line only if its priority is above both the threshold and the highest priority already in service on that CPU.

Software reads an acknowledge register to claim the winning request. The read returns the request's vector and moves it into service. Writing the end-of-interrupt register retires the highest in-service request. The highest-numbered sources are multicast sources. One edge on such a source is offered to every CPU in its destination mask, and each CPU claims it once. Ordinary sources go only to the lowest-numbered CPU in their mask.

Access is through a single-cycle register strobe. Read data is registered and is valid one cycle after the read strobe.

Top module: `pic_core`

## Requirements
- R1: After reset every CPU line is low, every task priority reads 15, the spurious vector reads 0xFF and every source configuration word reads 0x80000000 (masked).
- R2: Address map, on 12-bit addresses:
  - Source s has its configuration word at 0x20*s and its destination mask at 0x20*s+0x10.
  - The spurious vector is at 0x400.
  - CPU c has its task priority at 0x800+0x40*c, its acknowledge at +0x10 and its end-of-interrupt at +0x20.
  - Configuration word bits: bit 31 mask, bit 30 activity (read-only), bit 23 polarity (1 = active high), bit 22 sense (1 = level), bits 19:16 priority, bits 7:0 vector.
  - The destination mask uses bit c for CPU c.
- R3: The line of a CPU is high one cycle after a source is raised on it with a priority strictly above both its task priority and its highest in-service priority. The line is low otherwise.
- R4: Among raised sources the highest priority wins. On equal priority the lowest source number wins.
- R5: A masked source, or a source with an all-zero destination mask, is never delivered. An ordinary source is raised only on the lowest-numbered CPU set in its destination mask.
- R6: An acknowledge read returns the winner's vector, puts the winner in service and forces the line low in the following cycle. It returns the spurious vector when nothing is raised or the best priority is not above the task priority, and in that case it changes no state.
- R7: An end-of-interrupt write retires the highest-priority in-service source and is ignored when nothing is in service. A lower raised request that was hidden is delivered afterwards.
- R8: A task-priority write takes the low 4 bits and immediately re-gates the line against the new threshold.
- R9: An edge source latches a request on an inactive-to-active transition, and the acknowledge clears it. A level source is requested while its input is active, and the acknowledge does not clear it.
- R10: For a multicast source, an acknowledge clears only the claiming CPU's bit of its working mask. The request stays raised for the CPUs still in that mask. Every new edge reloads the working mask from the destination mask.
- R11: An access whose address has any of bits 3:0 set is ignored. A read of such an address returns 0xFFFFFFFF.
- R12: The activity bit reads 1 while the source is raised or in service on any CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Raw source inputs |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| cpu_irq | output | NUM_CPU | One interrupt line per CPU |

## Verification
The hardest state to reach is a request that is raised but hidden behind a higher in-service request, so that the line is low for a reason other than the threshold. The stimulus holds two level sources active and claims the higher one. It then withdraws that input and retires it, and the lower one must then surface. The multicast path is reached by claiming one edge on one CPU while the other CPU's line must stay high. The threshold gate is swept over all sixteen task-priority values against a fixed source priority.

// File: rtl/pic_pkg.sv
package pic_pkg;
    parameter int PRIO_W = 4;
    parameter int VEC_W  = 8;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 12;

    localparam int BIT_MASK  = 31;
    localparam int BIT_ACT   = 30;
    localparam int BIT_POL   = 23;
    localparam int BIT_SENSE = 22;
    localparam int PRIO_LSB  = 16;

    typedef struct packed {
        logic              msk;
        logic              pol;
        logic              sense;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } src_cfg_t;

    typedef enum logic [2:0] {
        ACC_NONE, ACC_SRC_CFG, ACC_SRC_DST, ACC_SPUR, ACC_TPR, ACC_ACK, ACC_EOI
    } acc_kind_t;

    localparam src_cfg_t CFG_RESET = '{msk: 1'b1, pol: 1'b0, sense: 1'b0,
                                       prio: '0, vec: '0};

    function automatic src_cfg_t cfg_from_word(logic [DATA_W-1:0] w);
        src_cfg_t c;
        c.msk   = w[BIT_MASK];
        c.pol   = w[BIT_POL];
        c.sense = w[BIT_SENSE];
        c.prio  = w[PRIO_LSB +: PRIO_W];
        c.vec   = w[VEC_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(src_cfg_t c, logic act);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_MASK]              = c.msk;
        w[BIT_ACT]               = act;
        w[BIT_POL]               = c.pol;
        w[BIT_SENSE]             = c.sense;
        w[PRIO_LSB +: PRIO_W]    = c.prio;
        w[VEC_W-1:0]             = c.vec;
        return w;
    endfunction
endpackage

// File: rtl/pic_pick.sv
module pic_pick #(
    parameter int N  = 8,
    parameter int PW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          valid,
    input  logic [N-1:0][PW-1:0]  prio,
    output logic                  found,
    output logic [IW-1:0]         idx,
    output logic [PW-1:0]         best
);
    // Scan from the top down with >=, so the lowest index survives a tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid[i] && (!found || prio[i] >= best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio[i];
            end
        end
    end

    AST_PICK_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        found |-> valid[idx]); // R4
endmodule

// File: rtl/pic_source.sv
module pic_source
    import pic_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter bit MCAST   = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_in,
    input  logic               cfg_wr,
    input  logic               dst_wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_CPU-1:0] take,
    output src_cfg_t           cfg,
    output logic [NUM_CPU-1:0] dest,
    output logic [NUM_CPU-1:0] live,
    output logic               pend
);
    src_cfg_t           cfg_q;
    logic [NUM_CPU-1:0] dest_q, live_q, live_n;
    logic               lvl_q, epend_q, epend_n, active, edge_seen;

    assign active    = cfg_q.pol ? irq_in : ~irq_in;
    assign edge_seen = active & ~lvl_q & ~cfg_q.sense;

    always_comb begin
        if (MCAST) begin
            if (dst_wr)         live_n = wdata[NUM_CPU-1:0];
            else if (edge_seen) live_n = dest_q;
            else                live_n = live_q & ~take;
        end else begin
            live_n = dest_q;
        end
        if (cfg_q.sense)    epend_n = 1'b0;
        else if (edge_seen) epend_n = 1'b1;
        else if (MCAST)     epend_n = epend_q & (|live_n);
        else                epend_n = epend_q & ~(|take);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RESET;
            dest_q  <= '0;
            live_q  <= '0;
            lvl_q   <= 1'b1;
            epend_q <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q  <= cfg_from_word(wdata);
            if (dst_wr) dest_q <= wdata[NUM_CPU-1:0];
            live_q  <= live_n;
            lvl_q   <= active;
            epend_q <= epend_n;
        end
    end

    assign cfg  = cfg_q;
    assign dest = dest_q;
    assign live = live_q;
    assign pend = cfg_q.sense ? lvl_q : epend_q;

    generate
        if (MCAST) begin : g_mc_chk
            AST_MCAST_BIT_DROPS: assert property (@(posedge clk) disable iff (rst)
                (|take) && !edge_seen && !dst_wr |=> (live & $past(take)) == '0); // R10
        end else begin : g_uc_chk
            AST_EDGE_CLEARS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
                (|take) && !edge_seen && !cfg_q.sense && !cfg_wr |=> !pend); // R9
        end
    endgenerate
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int NUM_CPU   = 2,
    parameter int NUM_MCAST = 2,
    localparam int SRC_IW   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CPU_IW   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int MCAST_LO = NUM_SRC - NUM_MCAST
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);
    acc_kind_t          kind;
    logic [SRC_IW-1:0]  sel_src;
    logic [CPU_IW-1:0]  sel_cpu;

    // Address decode; anything with a nonzero low nibble stays ACC_NONE.
    always_comb begin
        kind    = ACC_NONE;
        sel_src = '0;
        sel_cpu = '0;
        if (reg_addr[3:0] == 4'h0) begin
            if (reg_addr[11:8] == 4'h0 && int'(reg_addr[7:5]) < NUM_SRC) begin
                sel_src = SRC_IW'(reg_addr[7:5]);
                kind    = reg_addr[4] ? ACC_SRC_DST : ACC_SRC_CFG;
            end else if (reg_addr == 12'h400) begin
                kind = ACC_SPUR;
            end else if (reg_addr[11] && int'(reg_addr[10:6]) < NUM_CPU) begin
                sel_cpu = CPU_IW'(reg_addr[10:6]);
                case (reg_addr[5:4])
                    2'd0:    kind = ACC_TPR;
                    2'd1:    kind = ACC_ACK;
                    2'd2:    kind = ACC_EOI;
                    default: kind = ACC_NONE;
                endcase
            end
        end
    end

    src_cfg_t                          cfg [NUM_SRC];
    logic [NUM_SRC-1:0][NUM_CPU-1:0]   dest, live, tgt, take;
    logic [NUM_SRC-1:0]                pend, act;
    logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_arr;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]   raised, insvc_q;
    logic [NUM_CPU-1:0]                r_found, s_found, ack_hit, ack_ok, eoi_hit, irq_q;
    logic [NUM_CPU-1:0][SRC_IW-1:0]    r_idx, s_idx;
    logic [NUM_CPU-1:0][PRIO_W-1:0]    r_prio, s_prio, tpr_q;
    logic [VEC_W-1:0]                  spur_q;

    genvar s, c;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            pic_source #(.NUM_CPU(NUM_CPU), .MCAST(s >= MCAST_LO)) src_i (
                .clk(clk), .rst(rst), .irq_in(irq_in[s]),
                .cfg_wr(reg_wr && kind == ACC_SRC_CFG && sel_src == SRC_IW'(s)),
                .dst_wr(reg_wr && kind == ACC_SRC_DST && sel_src == SRC_IW'(s)),
                .wdata(reg_wdata), .take(take[s]),
                .cfg(cfg[s]), .dest(dest[s]), .live(live[s]), .pend(pend[s]));
            assign prio_arr[s] = cfg[s].prio;
            if (s >= MCAST_LO) begin : g_mc
                assign tgt[s] = live[s];
            end else begin : g_uc
                assign tgt[s] = dest[s] & (~dest[s] + 1'b1);
            end
            always_comb begin
                act[s] = 1'b0;
                for (int k = 0; k < NUM_CPU; k++) begin
                    take[s][k] = ack_ok[k] && r_idx[k] == SRC_IW'(s);
                    act[s]     = act[s] | raised[k][s] | insvc_q[k][s];
                end
            end
        end

        for (c = 0; c < NUM_CPU; c++) begin : g_cpu
            logic [PRIO_W-1:0] svc_lvl;
            logic              deliver;

            for (s = 0; s < NUM_SRC; s++) begin : g_rs
                assign raised[c][s] = pend[s] & ~cfg[s].msk & tgt[s][c] & ~insvc_q[c][s];
            end

            pic_pick #(.N(NUM_SRC), .PW(PRIO_W)) pick_raised_i (
                .clk(clk), .rst(rst), .valid(raised[c]), .prio(prio_arr),
                .found(r_found[c]), .idx(r_idx[c]), .best(r_prio[c]));
            pic_pick #(.N(NUM_SRC), .PW(PRIO_W)) pick_svc_i (
                .clk(clk), .rst(rst), .valid(insvc_q[c]), .prio(prio_arr),
                .found(s_found[c]), .idx(s_idx[c]), .best(s_prio[c]));

            assign svc_lvl    = s_found[c] ? s_prio[c] : '0;
            assign deliver    = r_found[c] && r_prio[c] > tpr_q[c] && r_prio[c] > svc_lvl;
            assign ack_hit[c] = reg_rd && kind == ACC_ACK && sel_cpu == CPU_IW'(c);
            assign ack_ok[c]  = ack_hit[c] && r_found[c] && r_prio[c] > tpr_q[c];
            assign eoi_hit[c] = reg_wr && kind == ACC_EOI && sel_cpu == CPU_IW'(c);

            always_ff @(posedge clk) begin
                if (rst) begin
                    tpr_q[c]   <= '1;
                    insvc_q[c] <= '0;
                    irq_q[c]   <= 1'b0;
                end else begin
                    if (reg_wr && kind == ACC_TPR && sel_cpu == CPU_IW'(c))
                        tpr_q[c] <= reg_wdata[PRIO_W-1:0];
                    for (int k = 0; k < NUM_SRC; k++) begin
                        insvc_q[c][k] <= (insvc_q[c][k] &
                            ~(eoi_hit[c] && s_found[c] && s_idx[c] == SRC_IW'(k)))
                            | take[k][c];
                    end
                    irq_q[c] <= ack_hit[c] ? 1'b0 : deliver;
                end
            end

            AST_ACK_DROPS_LINE: assert property (@(posedge clk) disable iff (rst)
                ack_hit[c] |=> !irq_q[c]); // R6
            AST_ACK_ENTERS_SVC: assert property (@(posedge clk) disable iff (rst)
                ack_ok[c] |=> insvc_q[c][$past(r_idx[c])]); // R6
            AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (rst)
                eoi_hit[c] && !s_found[c] && !reg_rd |=> insvc_q[c] == '0); // R7
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            spur_q    <= '1;
            reg_rdata <= '0;
        end else begin
            if (reg_wr && kind == ACC_SPUR) spur_q <= reg_wdata[VEC_W-1:0];
            if (reg_rd) begin
                case (kind)
                    ACC_SRC_CFG: reg_rdata <= cfg_to_word(cfg[sel_src], act[sel_src]);
                    ACC_SRC_DST: reg_rdata <= DATA_W'(dest[sel_src]);
                    ACC_SPUR:    reg_rdata <= DATA_W'(spur_q);
                    ACC_TPR:     reg_rdata <= DATA_W'(tpr_q[sel_cpu]);
                    ACC_ACK:     reg_rdata <= ack_ok[sel_cpu] ?
                                     DATA_W'(cfg[r_idx[sel_cpu]].vec) : DATA_W'(spur_q);
                    ACC_EOI:     reg_rdata <= '0;
                    default:     reg_rdata <= (reg_addr[3:0] != 4'h0) ? '1 : '0;
                endcase
            end
        end
    end

    assign cpu_irq = irq_q;

    AST_UNALIGNED_READ: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr[3:0] != 4'h0 |=> reg_rdata == '1); // R11
endmodule

// File: tb/pic_core_tb.sv
module pic_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;
    localparam int NCPU = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] irq_in = '0;
    logic            reg_rd = 1'b0, reg_wr = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0, reg_rdata;
    logic [NCPU-1:0] cpu_irq;

    int checks = 0, errors = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_core #(.NUM_SRC(NSRC), .NUM_CPU(NCPU), .NUM_MCAST(2)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq));

    function automatic logic [11:0] a_cfg(int s); return 12'(s * 32); endfunction
    function automatic logic [11:0] a_dst(int s); return 12'(s * 32 + 16); endfunction
    function automatic logic [11:0] a_tpr(int c); return 12'(12'h800 + c * 64); endfunction
    function automatic logic [11:0] a_ack(int c); return 12'(12'h810 + c * 64); endfunction
    function automatic logic [11:0] a_eoi(int c); return 12'(12'h820 + c * 64); endfunction
    function automatic logic [31:0] word(int msk, int pol, int sense, int prio, int vec);
        return (32'(msk) << 31) | (32'(pol) << 23) | (32'(sense) << 22)
             | (32'(prio) << 16) | 32'(vec);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(int s);
        @(negedge clk); irq_in[s] = 1'b1;
        @(negedge clk); irq_in[s] = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk("R1 line", 32'(cpu_irq), 0);
        rd(a_tpr(0), rv);     chk("R1 tpr", rv, 15);
        rd(12'h400, rv);      chk("R1 spurious", rv, 32'hFF);
        rd(a_cfg(0), rv);     chk("R1 cfg", rv, 32'h8000_0000);

        // Edge source on CPU0
        wr(a_cfg(0), word(0, 1, 0, 5, 8'h40));
        wr(a_dst(0), 32'b01);
        wr(a_tpr(0), 0);
        pulse(0); settle();
        chk("R3 edge delivered", 32'(cpu_irq[0]), 1);
        rd(a_ack(0), rv);     chk("R6 ack vector", rv, 32'h40);
        chk("R6 line low after ack", 32'(cpu_irq[0]), 0);
        rd(a_cfg(0), rv);     chk("R12 active in service", rv, word(0, 1, 0, 5, 8'h40) | 32'h4000_0000);
        wr(a_eoi(0), 0);
        rd(a_cfg(0), rv);     chk("R2 cfg readback idle", rv, word(0, 1, 0, 5, 8'h40));
        rd(a_ack(0), rv);     chk("R9 edge cleared by ack", rv, 32'hFF);

        // Threshold sweep with a level source of priority 7
        wr(a_cfg(0), word(0, 1, 1, 7, 8'h70));
        irq_in[0] = 1'b1;
        for (int t = 0; t < 16; t++) begin
            wr(a_tpr(0), 32'(t) | 32'hF0);
            settle();
            chk("R8 threshold sweep", 32'(cpu_irq[0]), (7 > t) ? 1 : 0);
        end
        wr(a_tpr(0), 0); settle();
        rd(a_ack(0), rv);     chk("R6 level ack", rv, 32'h70);
        settle();
        chk("R3 hidden by own service", 32'(cpu_irq[0]), 0);
        wr(a_eoi(0), 0); settle();
        chk("R9 level stays requested", 32'(cpu_irq[0]), 1);
        irq_in[0] = 1'b0; settle();
        chk("R9 level follows input", 32'(cpu_irq[0]), 0);
        rd(a_ack(0), rv);     chk("R6 spurious when empty", rv, 32'hFF);
        wr(a_cfg(0), word(1, 1, 1, 7, 8'h70));

        // Arbitration sweep over two level sources
        wr(a_dst(1), 32'b01); wr(a_dst(2), 32'b01);
        irq_in[1] = 1'b1; irq_in[2] = 1'b1;
        for (int pa = 1; pa <= 3; pa++) begin
            for (int pb = 1; pb <= 3; pb++) begin
                wr(a_cfg(1), word(0, 1, 1, pa, 8'h11));
                wr(a_cfg(2), word(0, 1, 1, pb, 8'h22));
                settle();
                rd(a_ack(0), rv);
                chk("R4 arbitration", rv, (pa >= pb) ? 32'h11 : 32'h22);
                wr(a_eoi(0), 0);
            end
        end
        // Nesting: priority 6 in service hides priority 3
        wr(a_cfg(1), word(0, 1, 1, 3, 8'h11));
        wr(a_cfg(2), word(0, 1, 1, 6, 8'h22));
        settle();
        rd(a_ack(0), rv);     chk("R4 higher wins", rv, 32'h22);
        settle();
        chk("R3 lower hidden by service", 32'(cpu_irq[0]), 0);
        irq_in[2] = 1'b0;
        wr(a_eoi(0), 0); settle();
        chk("R7 hidden request surfaces", 32'(cpu_irq[0]), 1);
        rd(a_ack(0), rv);     chk("R7 next vector", rv, 32'h11);
        wr(a_eoi(0), 0);
        wr(a_eoi(0), 0); settle();
        rd(a_ack(0), rv);     chk("R7 empty eoi ignored", rv, 32'h11);
        wr(a_eoi(0), 0);
        irq_in[1] = 1'b0;
        wr(a_cfg(1), word(1, 1, 1, 3, 8'h11));
        wr(a_cfg(2), word(1, 1, 1, 6, 8'h22));

        // Destination and mask
        wr(a_tpr(1), 0);
        wr(a_cfg(3), word(0, 1, 1, 9, 8'h33));
        irq_in[3] = 1'b1; settle();
        chk("R5 zero destination", 32'(cpu_irq), 0);
        rd(a_ack(0), rv);     chk("R5 zero destination ack", rv, 32'hFF);
        wr(a_dst(3), 32'b10); settle();
        chk("R5 routed to cpu1", 32'(cpu_irq), 32'b10);
        wr(a_dst(3), 32'b11); settle();
        chk("R5 lowest cpu only", 32'(cpu_irq), 32'b01);
        wr(a_cfg(3), word(1, 1, 1, 9, 8'h33)); settle();
        chk("R5 masked", 32'(cpu_irq), 0);
        irq_in[3] = 1'b0;

        // Multicast source 6
        wr(a_cfg(6), word(0, 1, 0, 4, 8'h66));
        wr(a_dst(6), 32'b11);
        pulse(6); settle();
        chk("R10 both lines", 32'(cpu_irq), 32'b11);
        rd(a_ack(0), rv);     chk("R10 cpu0 claims", rv, 32'h66);
        settle();
        chk("R10 cpu1 still raised", 32'(cpu_irq), 32'b10);
        rd(a_ack(1), rv);     chk("R10 cpu1 claims", rv, 32'h66);
        wr(a_eoi(0), 0); wr(a_eoi(1), 0); settle();
        chk("R10 drained lines", 32'(cpu_irq), 0);
        rd(a_ack(0), rv);     chk("R10 no repeat cpu0", rv, 32'hFF);

        // Unaligned access and spurious vector
        wr(12'h804, 9);
        rd(a_tpr(0), rv);     chk("R11 unaligned write ignored", rv, 0);
        rd(12'h808, rv);      chk("R11 unaligned read", rv, 32'hFFFF_FFFF);
        rd(12'h814, rv);      chk("R11 unaligned ack", rv, 32'hFFFF_FFFF);
        wr(12'h400, 32'h3C);
        rd(a_ack(1), rv);     chk("R6 programmed spurious", rv, 32'h3C);

        finish_run();
    end
endmodule